// File: doc/BRIEF.md
# Protected Paging Controller

This block watches a Z80-style expansion bus, one sample per clock, and decides which 64K RAM bank the expansion memory presents. There are three choices: the operating system's base bank, an application's private bank, and an interrupt-catch bank. The block keeps its own copy of the RAM paging mode by watching writes to the paging port. It also keeps a copy of the extended bank number from the expansion bank port. An application runs in its bank only once the operating system has finished a deliberate return sequence.

While the application bank is active, the application cannot touch hardware. Any I/O write it makes is held back from downstream devices. That write raises an NMI, and the base bank is paged in only after the CPU has pushed its two return-address bytes. A maskable interrupt acknowledge taken from the application pages in the interrupt-catch bank. Writes to that bank are discarded. An opcode fetch from 0x0038 then brings back the base bank. A free-running timer raises a periodic NMI. NMI requests that arrive while one is still being serviced are held and issued afterwards.

To return to the application, the operating system takes three steps. It writes to the block's own port to arm the return. It writes the paging port with the application mode, and the block captures that value without applying it. It then executes RET. When the block sees the opcode fetch of 0xC9, the captured mode and the extended bank take effect.

Top module: `prot_page_ctrl`

## Requirements
- R1: After reset, bankSel is 0 (base bank), nmiOut is 0, extBank is 0, ramWrEn and ioPassEn are 1, and the NMI timer is loaded with TICK_PERIOD-1.
- R2: A paging-mode write is an I/O write with address[15:8]=0x7F and data[7:6]=2'b11, and its mode is data[2:0]. Mode 2 means application. An I/O write to 0x7F whose data[7:6] is not 2'b11 is not a mode write.
- R3: An I/O write that completes while bankSel is 1 (application) raises a one-cycle nmiOut pulse.
- R4: ioPassEn is 0 while an I/O write is on the bus with bankSel=1, and it is 1 during I/O writes in the other banks.
- R5: After an NMI is issued, bankSel does not change on the first completed memory write. It changes to 0 when the second completed memory write ends.
- R6: An interrupt acknowledge (M1 together with IORQ) that completes in bankSel=1 selects bankSel=2 (interrupt bank). While bankSel=2, ramWrEn is 0 during memory writes, and ramWrEn is 1 during memory writes in bank 1.
- R7: In bankSel=2, an opcode fetch (M1, MREQ and RD) from address 0x0038 selects bankSel=0. A fetch from any other address leaves the bank unchanged.
- R8: Periodic NMI pulses are TICK_PERIOD clock cycles apart when each one is serviced before the next is due.
- R9: An I/O write to address[15:8]=0xFE arms the return. While armed, a mode-2 paging write is captured and not applied, so bankSel stays 0. A later fetch of opcode 0xC9 selects bankSel=1. A fetch of any other opcode does nothing.
- R10: An I/O write to address[15:8]=0x7E sets extBank to data[EXT_W-1:0] at once when the return is not armed. When the return is armed, the new value appears only when the RET fetch completes the return.
- R11: No new nmiOut pulse is issued while an NMI is still awaiting its two stack writes. A request raised during that time is issued once the bank has switched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; bus strobes are sampled on its rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 16 | CPU address bus |
| busData | input | 8 | CPU data bus (snooped) |
| busM1 | input | 1 | Machine-cycle-one strobe, active high |
| busMreq | input | 1 | Memory request, active high |
| busIorq | input | 1 | I/O request, active high |
| busRd | input | 1 | Read strobe, active high |
| busWr | input | 1 | Write strobe, active high |
| bankSel | output | 2 | 0 base bank, 1 application bank, 2 interrupt bank |
| extBank | output | EXT_W | Extended RAM bank number |
| ramWrEn | output | 1 | Write enable forwarded to expansion RAM |
| ioPassEn | output | 1 | Enables I/O strobes toward downstream devices |
| nmiOut | output | 1 | One-cycle NMI request pulse, active high |

## Verification
A trap and a pending NMI can land on the same service window. An application I/O write can complete while an earlier NMI is still waiting for its stack pushes, because the bank stays on the application until the second push. The bench provokes this by issuing a second trapped write between the first NMI pulse and its stack writes. It judges the result by checking that no second pulse appears until both writes have switched the bank to base, and that exactly one further pulse follows.

// File: rtl/ppc_pkg.sv
package ppc_pkg;

  typedef enum logic [1:0] {
    BANK_BASE = 2'd0,
    BANK_APP  = 2'd1,
    BANK_INTR = 2'd2
  } bank_e;

  // decoded bus events, each valid for the single completion cycle
  typedef struct packed {
    logic ioWr;
    logic pageWr;
    logic pageApp;
    logic extWr;
    logic ownWr;
    logic memWr;
    logic inta;
    logic fetchVec;
    logic fetchRet;
  } bus_ev_t;

  // strobes from control to the shadow datapath
  typedef struct packed {
    logic ldMode;
    logic capMode;
    logic ldExt;
    logic capExt;
    logic arm;
    logic commit;
  } dp_ctl_t;

endpackage

// File: rtl/ppc_datapath.sv
module ppc_datapath
  import ppc_pkg::*;
#(
  parameter int          EXT_W     = 3,
  parameter logic [7:0]  PAGE_PORT = 8'h7F,
  parameter logic [7:0]  EXT_PORT  = 8'h7E,
  parameter logic [7:0]  OWN_PORT  = 8'hFE,
  parameter logic [2:0]  MODE_APP  = 3'd2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [15:0]      busAddr,
  input  logic [7:0]       busData,
  input  logic             busM1,
  input  logic             busMreq,
  input  logic             busIorq,
  input  logic             busRd,
  input  logic             busWr,
  input  dp_ctl_t          ctl,
  output bus_ev_t          ev,
  output logic             modeApp,
  output logic [EXT_W-1:0] extBank
);

  logic [15:0]      pAddr;
  logic [7:0]       pData;
  logic             pM1, pMreq, pIorq, pRd, pWr;
  logic [2:0]       modeNow, modePend;
  logic [EXT_W-1:0] extNow, extPend;
  logic             memDone, ioDone, fetch;

  // one-cycle delayed copy of the bus; completion = strobe falling
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pAddr <= '0; pData <= '0;
      pM1 <= 1'b0; pMreq <= 1'b0; pIorq <= 1'b0; pRd <= 1'b0; pWr <= 1'b0;
    end else begin
      pAddr <= busAddr; pData <= busData;
      pM1 <= busM1; pMreq <= busMreq; pIorq <= busIorq; pRd <= busRd; pWr <= busWr;
    end
  end

  assign memDone = pMreq & ~busMreq;
  assign ioDone  = pIorq & ~busIorq;
  assign fetch   = memDone & pM1 & pRd;

  always_comb begin
    ev          = '0;
    ev.ioWr     = ioDone & pWr & ~pM1;
    ev.pageWr   = ev.ioWr & (pAddr[15:8] == PAGE_PORT) & (pData[7:6] == 2'b11); // R2
    ev.pageApp  = (pData[2:0] == MODE_APP);
    ev.extWr    = ev.ioWr & (pAddr[15:8] == EXT_PORT);
    ev.ownWr    = ev.ioWr & (pAddr[15:8] == OWN_PORT);
    ev.memWr    = memDone & pWr & ~pM1;
    ev.inta     = ioDone & pM1;
    ev.fetchVec = fetch & (pAddr == 16'h0038);
    ev.fetchRet = fetch & (pData == 8'hC9);
  end

  // shadow and captured registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeNow <= '0; modePend <= '0; extNow <= '0; extPend <= '0;
    end else begin
      if (ctl.ldMode)  modeNow  <= pData[2:0];
      if (ctl.capMode) modePend <= pData[2:0];
      if (ctl.arm)     extPend  <= extNow;
      if (ctl.ldExt)   extNow   <= pData[EXT_W-1:0];
      if (ctl.capExt)  extPend  <= pData[EXT_W-1:0];
      if (ctl.commit) begin
        modeNow <= modePend;
        extNow  <= extPend;
      end
    end
  end

  assign modeApp = (modeNow == MODE_APP);
  assign extBank = extNow;

endmodule

// File: rtl/ppc_control.sv
module ppc_control
  import ppc_pkg::*;
#(
  parameter int TICK_PERIOD = 1_200_000,
  localparam int CNT_W = $clog2(TICK_PERIOD)
) (
  input  logic       clk,
  input  logic       rstN,
  input  bus_ev_t    ev,
  input  logic       modeApp,
  input  logic       busIorq,
  input  logic       busMreq,
  input  logic       busWr,
  output dp_ctl_t    ctl,
  output logic [1:0] bankSel,
  output logic       ramWrEn,
  output logic       ioPassEn,
  output logic       nmiOut
);

  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(TICK_PERIOD - 1);

  logic             osForce, intrBank, armed, captured, pending, req, pushOne;
  logic [CNT_W-1:0] tmr;
  logic             isApp, trap, tick, issue, pushDone;
  bank_e            bank;

  always_comb begin
    if (intrBank)                bank = BANK_INTR;
    else if (osForce | ~modeApp) bank = BANK_BASE;
    else                         bank = BANK_APP;
  end

  assign isApp    = (bank == BANK_APP);
  assign trap     = ev.ioWr & isApp;                       // R3
  assign tick     = (tmr == '0);                           // R8
  assign issue    = (req | trap | tick) & ~pending;        // R11
  assign pushDone = pending & ev.memWr & pushOne;          // R5

  always_comb begin
    ctl         = '0;
    ctl.ldMode  = ev.pageWr & ~isApp & ~(armed & ev.pageApp);
    ctl.capMode = ev.pageWr & ~isApp & armed & ev.pageApp; // R9
    ctl.ldExt   = ev.extWr & ~isApp & ~armed;              // R10
    ctl.capExt  = ev.extWr & ~isApp & armed;
    ctl.arm     = ev.ownWr & ~isApp;
    ctl.commit  = ev.fetchRet & captured & ~isApp;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tmr      <= RELOAD;
      osForce  <= 1'b1;
      intrBank <= 1'b0;
      armed    <= 1'b0;
      captured <= 1'b0;
      pending  <= 1'b0;
      req      <= 1'b0;
      pushOne  <= 1'b0;
      nmiOut   <= 1'b0;
    end else begin
      tmr    <= tick ? RELOAD : tmr - 1'b1;
      req    <= (req | trap | tick) & pending;
      nmiOut <= issue;
      if (issue) begin
        pending <= 1'b1;
        pushOne <= 1'b0;
      end else if (pushDone) begin
        pending  <= 1'b0;
        pushOne  <= 1'b0;
        osForce  <= 1'b1;
        intrBank <= 1'b0;
      end else if (pending & ev.memWr) begin
        pushOne <= 1'b1;
      end
      if (ev.inta & isApp) intrBank <= 1'b1;               // R6
      if (ev.fetchVec & intrBank & ~pushDone) begin        // R7
        intrBank <= 1'b0;
        osForce  <= 1'b1;
      end
      if (ctl.arm) begin
        armed    <= 1'b1;
        captured <= 1'b0;
      end
      if (ctl.capMode) captured <= 1'b1;
      if (ctl.commit) begin
        osForce  <= 1'b0;
        armed    <= 1'b0;
        captured <= 1'b0;
      end
    end
  end

  assign bankSel  = bank;
  assign ramWrEn  = ~(intrBank & busMreq & busWr);
  assign ioPassEn = ~(isApp & busIorq & busWr);            // R4

endmodule

// File: rtl/prot_page_ctrl.sv
module prot_page_ctrl
  import ppc_pkg::*;
#(
  parameter int TICK_PERIOD = 1_200_000,
  parameter int EXT_W       = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [15:0]      busAddr,
  input  logic [7:0]       busData,
  input  logic             busM1,
  input  logic             busMreq,
  input  logic             busIorq,
  input  logic             busRd,
  input  logic             busWr,
  output logic [1:0]       bankSel,
  output logic [EXT_W-1:0] extBank,
  output logic             ramWrEn,
  output logic             ioPassEn,
  output logic             nmiOut
);

  bus_ev_t ev;
  dp_ctl_t ctl;
  logic    modeApp;

  ppc_datapath #(.EXT_W(EXT_W)) u_dp (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busData(busData),
    .busM1(busM1), .busMreq(busMreq), .busIorq(busIorq), .busRd(busRd),
    .busWr(busWr), .ctl(ctl), .ev(ev), .modeApp(modeApp), .extBank(extBank)
  );

  ppc_control #(.TICK_PERIOD(TICK_PERIOD)) u_ctl (
    .clk(clk), .rstN(rstN), .ev(ev), .modeApp(modeApp),
    .busIorq(busIorq), .busMreq(busMreq), .busWr(busWr), .ctl(ctl),
    .bankSel(bankSel), .ramWrEn(ramWrEn), .ioPassEn(ioPassEn), .nmiOut(nmiOut)
  );

endmodule

// File: rtl/ppc_checker.sv
module ppc_checker (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] bankSel,
  input logic       nmiOut,
  input logic       ioPassEn
);

  p_nmi_single_r11: assert property (@(posedge clk) disable iff (!rstN)
    nmiOut |=> !nmiOut);

  p_intr_exit_base_r7: assert property (@(posedge clk) disable iff (!rstN)
    (bankSel == 2'd2) |=> (bankSel == 2'd2 || bankSel == 2'd0));

  p_app_entry_from_base_r9: assert property (@(posedge clk) disable iff (!rstN)
    (bankSel == 2'd1 && $past(bankSel) != 2'd1) |-> ($past(bankSel) == 2'd0));

  p_base_passes_io_r4: assert property (@(posedge clk) disable iff (!rstN)
    (bankSel == 2'd0) |-> ioPassEn);

  p_no_bad_code_r6: assert property (@(posedge clk) disable iff (!rstN)
    bankSel != 2'd3);

endmodule

bind prot_page_ctrl ppc_checker u_chk (
  .clk(clk), .rstN(rstN), .bankSel(bankSel), .nmiOut(nmiOut), .ioPassEn(ioPassEn)
);

// File: tb/prot_page_ctrl_bench.sv
`timescale 1ns/1ps
module prot_page_ctrl_bench;

  localparam int PER = 500;
  localparam int NV  = 16;

  logic clk = 1'b0, rstN = 1'b0;
  logic [15:0] busAddr = '0;
  logic [7:0]  busData = '0;
  logic busM1 = 0, busMreq = 0, busIorq = 0, busRd = 0, busWr = 0;
  logic [1:0] bankSel;
  logic [2:0] extBank;
  logic ramWrEn, ioPassEn, nmiOut;

  int checks = 0, fails = 0, nmiCnt = 0, cyc = 0;
  int nmiAt[$];
  bit done = 0;

  always #2.5 clk = ~clk;

  prot_page_ctrl #(.TICK_PERIOD(PER), .EXT_W(3)) u_prot_page_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busData(busData),
    .busM1(busM1), .busMreq(busMreq), .busIorq(busIorq), .busRd(busRd),
    .busWr(busWr), .bankSel(bankSel), .extBank(extBank), .ramWrEn(ramWrEn),
    .ioPassEn(ioPassEn), .nmiOut(nmiOut)
  );

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (rstN && nmiOut) begin nmiCnt++; nmiAt.push_back(cyc); end

  // {kind 3, addr 16, data 8, expBank 2, expExt 3, expNmi 4, req 4}
  // kind: 0 I/O write, 1 memory write, 2 opcode fetch, 3 interrupt acknowledge
  localparam logic [39:0] TBL [NV] = '{
    {3'd0, 16'h7E00, 8'h05, 2'd0, 3'd5, 4'd0, 4'd10}, // R10 direct ext load
    {3'd0, 16'hFE00, 8'h00, 2'd0, 3'd5, 4'd0, 4'd9},  // R9 arm
    {3'd0, 16'h7F00, 8'hC2, 2'd0, 3'd5, 4'd0, 4'd9},  // R9 capture
    {3'd0, 16'h7E00, 8'h03, 2'd0, 3'd5, 4'd0, 4'd10}, // R10 held while armed
    {3'd2, 16'h1000, 8'h00, 2'd0, 3'd5, 4'd0, 4'd9},  // R9 non-RET fetch
    {3'd2, 16'h1001, 8'hC9, 2'd1, 3'd3, 4'd0, 4'd9},  // R9 R10 RET commits
    {3'd1, 16'h8000, 8'h11, 2'd1, 3'd3, 4'd0, 4'd5},
    {3'd3, 16'h0000, 8'hFF, 2'd2, 3'd3, 4'd0, 4'd6},  // R6 acknowledge
    {3'd2, 16'h1234, 8'hFF, 2'd2, 3'd3, 4'd0, 4'd7},  // R7 other address
    {3'd2, 16'h0038, 8'hF3, 2'd0, 3'd3, 4'd0, 4'd7},  // R7 vector fetch
    {3'd0, 16'hFE00, 8'h00, 2'd0, 3'd3, 4'd0, 4'd9},
    {3'd0, 16'h7F00, 8'hC2, 2'd0, 3'd3, 4'd0, 4'd2},  // R2 mode write
    {3'd2, 16'h2000, 8'hC9, 2'd1, 3'd3, 4'd0, 4'd9},
    {3'd0, 16'hBC00, 8'h01, 2'd1, 3'd3, 4'd1, 4'd3},  // R3 trap
    {3'd1, 16'hFFFE, 8'h20, 2'd1, 3'd3, 4'd1, 4'd5},  // R5 first push
    {3'd1, 16'hFFFD, 8'h00, 2'd0, 3'd3, 4'd1, 4'd5}   // R5 second push
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input int kind, input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busData = d;
    busM1   = (kind == 2 || kind == 3);
    busMreq = (kind == 1 || kind == 2);
    busIorq = (kind == 0 || kind == 3);
    busRd   = (kind == 2);
    busWr   = (kind == 0 || kind == 1);
  endtask

  task automatic release_bus();
    @(negedge clk);
    busM1 = 0; busMreq = 0; busIorq = 0; busRd = 0; busWr = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic op(input int kind, input logic [15:0] a, input logic [7:0] d);
    drive(kind, a, d);
    @(negedge clk);
    release_bus();
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    nmiCnt = 0; nmiAt.delete();
  endtask

  task automatic enterApp();
    op(0, 16'hFE00, 8'h00);
    op(0, 16'h7F00, 8'hC2);
    op(2, 16'h3000, 8'hC9);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    // R1 reset state
    repeat (2) @(negedge clk);
    chk("R1 bank", bankSel, 0);
    chk("R1 nmi", nmiOut, 0);
    chk("R1 ext", extBank, 0);
    chk("R1 wrEn", ramWrEn, 1);
    chk("R1 pass", ioPassEn, 1);
    doReset();

    // table walk: full protected flow
    for (int i = 0; i < NV; i++) begin
      logic [39:0] v;
      v = TBL[i];
      op(int'(v[39:37]), v[36:21], v[20:13]);
      chk($sformatf("R%0d row%0d bank", v[3:0], i), bankSel, int'(v[12:11]));
      chk($sformatf("R%0d row%0d ext", v[3:0], i), extBank, int'(v[10:8]));
      chk($sformatf("R%0d row%0d nmi", v[3:0], i), nmiCnt, int'(v[7:4]));
    end

    // R2: port 0x7F write without data[7:6]=11 is not captured
    doReset();
    op(0, 16'hFE00, 8'h00);
    op(0, 16'h7F00, 8'h42);
    op(2, 16'h1000, 8'hC9);
    chk("R2 non-mode write no return", bankSel, 0);

    // R4 gating in base and in application
    doReset();
    drive(0, 16'hBC00, 8'h00);
    @(negedge clk);
    chk("R4 base passes", ioPassEn, 1);
    release_bus();
    enterApp();
    chk("R4 in app", bankSel, 1);
    drive(0, 16'hBC00, 8'h00);
    @(negedge clk);
    chk("R4 app blocked", ioPassEn, 0);
    release_bus();

    // R6 write discard only in interrupt bank
    doReset();
    enterApp();
    drive(1, 16'h4000, 8'h00);
    @(negedge clk);
    chk("R6 app write enabled", ramWrEn, 1);
    release_bus();
    op(3, 16'h0000, 8'hFF);
    drive(1, 16'h4000, 8'h00);
    @(negedge clk);
    chk("R6 intr write dropped", ramWrEn, 0);
    release_bus();

    // R11 request during pending is held then issued
    doReset();
    enterApp();
    op(0, 16'hBC00, 8'h00);
    chk("R11 first pulse", nmiCnt, 1);
    op(0, 16'hBD00, 8'h00);
    chk("R11 held while pending", nmiCnt, 1);
    op(1, 16'hFFFE, 8'h00);
    chk("R11 still held", nmiCnt, 1);
    op(1, 16'hFFFD, 8'h00);
    chk("R11 bank base", bankSel, 0);
    chk("R11 held request issued", nmiCnt, 2);
    op(1, 16'hFFFC, 8'h00);
    op(1, 16'hFFFB, 8'h00);

    // R8 periodic interval
    doReset();
    while (nmiCnt < 1) @(negedge clk);
    op(1, 16'hF000, 8'h00);
    op(1, 16'hEFFF, 8'h00);
    while (nmiCnt < 2) @(negedge clk);
    chk("R8 period", nmiAt[1] - nmiAt[0], PER);

    done = 1;
    summary();
  end

endmodule